// File: doc/BRIEF.md
# Power-Up Strap Capture and Clock Release Sequencer

This block owns two pads that serve two purposes. While the supply comes up, the pads are inputs that carry configuration straps. The first pad selects the frequency and the second selects the spread amplitude. The block never drives either pad during this time. An external pull-up makes an unconnected pad read as 1.

When power-good rises, the block captures both pad levels on the next reference-clock edge. It then drives both pads low for a bounded power-up window. When the window ends, the pads carry the reference and 48 MHz clock sources, and every other clock output is released at the same moment.

The captured straps stay fixed until power-good falls. A fall sends the block back to the input phase and re-arms the capture. The frequency strap and a live select input are decoded into a CPU/PCI frequency code and the two nominal frequencies. The spread strap is decoded into a spread amplitude. All decoded values read zero until the sequence is done.

Top module: `strap_seq`

## Requirements
- R1: While `pwr_good` is low, every output enable is 0, `seq_done` is 0, and `freq_code`, `cpu_x100`, `pci_x100` and `spread_bp` are 0.
- R2: On the first `clk_ref` rising edge with `pwr_good` high, `pad_fs_in` is captured onto `strap_fs` and `pad_ss_in` is captured onto `strap_ss`.
- R3: After the capture, both pads and all other clock outputs are enabled and driven low for the whole power-up window.
- R4: The driven-low window lasts exactly TIMER_CYC reference cycles. `seq_done` rises on the edge TIMER_CYC+1 edges after `pwr_good` rose.
- R5: Once `seq_done` is high, each pad output and each other clock output equals its source: `src_ref` on the frequency pad, `src_usb` on the spread pad, and `src_oth` bit for bit on `oth_out`.
- R6: While `pwr_good` stays high, changes on the pad inputs after the capture never alter `strap_fs` or `strap_ss`.
- R7: With `seq_done` high, the pair {strap_fs, sel_hi} selects the frequency code and values as follows:
  - 11 gives code 0, CPU 10000 and PCI 3330.
  - 10 gives code 1, CPU 6680 and PCI 3340.
  - 01 gives code 2, CPU 11200 and PCI 3730.
  - 00 gives code 3, CPU 10300 and PCI 3434 is not used; PCI is 3433.
  - CPU and PCI are given in units of 10 kHz.
- R8: With `seq_done` high, `strap_ss` = 1 gives `spread_bp` = 50 (±0.5 % center) and `strap_ss` = 0 gives `spread_bp` = 75 (±0.75 % center).
- R9: During the driven-low window, all decoded outputs read 0.
- R10: A fall of `pwr_good` returns the block at once to the input phase. The next rise captures the pads again and repeats the whole sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock for the capture and the power-up timer |
| pwr_good | input | 1 | Supply-good indication; low acts as asynchronous reset |
| sel_hi | input | 1 | Live frequency select input |
| pad_fs_in | input | 1 | Level read from the frequency strap pad |
| pad_ss_in | input | 1 | Level read from the spread strap pad |
| src_ref | input | 1 | Reference clock source for the frequency pad |
| src_usb | input | 1 | 48 MHz source for the spread pad |
| src_oth | input | N_OTH | Other internal clock sources |
| pad_fs_oe | output | 1 | Output enable of the frequency pad |
| pad_fs_out | output | 1 | Output value of the frequency pad |
| pad_ss_oe | output | 1 | Output enable of the spread pad |
| pad_ss_out | output | 1 | Output value of the spread pad |
| oth_oe | output | N_OTH | Output enables of the other clocks |
| oth_out | output | N_OTH | Gated values of the other clocks |
| strap_fs | output | 1 | Captured frequency strap |
| strap_ss | output | 1 | Captured spread strap |
| seq_done | output | 1 | High once the clocks toggle |
| freq_code | output | 2 | Decoded frequency code |
| cpu_x100 | output | 16 | CPU frequency in units of 10 kHz |
| pci_x100 | output | 16 | PCI frequency in units of 10 kHz |
| spread_bp | output | 7 | Spread amplitude in hundredths of a percent |

## Verification
The bench builds the block with TIMER_CYC = 20 and N_OTH = 3. The short window lets it observe the exact cycle on which `seq_done` rises, and the cycle just before it. It also gives time for two full power cycles with opposite strap values, so all four frequency codes and both spread amplitudes are reached. Three other clocks are enough to show per-bit gating with non-uniform source patterns.

// File: rtl/strap_pkg.sv
package strap_pkg;

  typedef enum logic [1:0] {
    PH_INPUT = 2'd0,
    PH_LOW   = 2'd1,
    PH_RUN   = 2'd2
  } phase_t;

  typedef struct packed {
    logic fs;
    logic ss;
  } strap_t;

  // {strap, select} -> frequency code
  function automatic logic [1:0] freq_code_f(input logic fs, input logic sel);
    case ({fs, sel})
      2'b11:   return 2'd0;
      2'b10:   return 2'd1;
      2'b01:   return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  // CPU frequency, units of 10 kHz
  function automatic logic [15:0] cpu_x100_f(input logic [1:0] code);
    case (code)
      2'd0:    return 16'd10000;
      2'd1:    return 16'd6680;
      2'd2:    return 16'd11200;
      default: return 16'd10300;
    endcase
  endfunction

  // PCI frequency, units of 10 kHz
  function automatic logic [15:0] pci_x100_f(input logic [1:0] code);
    case (code)
      2'd0:    return 16'd3330;
      2'd1:    return 16'd3340;
      2'd2:    return 16'd3730;
      default: return 16'd3433;
    endcase
  endfunction

  // spread amplitude, hundredths of a percent
  function automatic logic [6:0] spread_bp_f(input logic ss);
    return ss ? 7'd50 : 7'd75;
  endfunction

endpackage

// File: rtl/strap_timer.sv
module strap_timer
  import strap_pkg::*;
#(
  parameter int TIMER_CYC = 42954
) (
  input  logic   clk_ref,
  input  logic   pwr_good,
  output phase_t phase,
  output logic   cap_ev,
  output logic   in_low,
  output logic   run
);
  localparam int CW = (TIMER_CYC > 1) ? $clog2(TIMER_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMER_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk_ref or negedge pwr_good) begin
    if (!pwr_good) begin
      phase <= PH_INPUT;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_INPUT: begin
          phase <= PH_LOW;
          cnt   <= '0;
        end
        PH_LOW: begin
          if (cnt == LAST) phase <= PH_RUN;
          else             cnt   <= cnt + 1'b1;
        end
        default: phase <= PH_RUN;
      endcase
    end
  end

  assign cap_ev = pwr_good && (phase == PH_INPUT);
  assign in_low = (phase == PH_LOW);
  assign run    = (phase == PH_RUN);
endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import strap_pkg::*;
(
  input  logic   clk_ref,
  input  logic   pwr_good,
  input  logic   cap_ev,
  input  logic   pad_fs_in,
  input  logic   pad_ss_in,
  output strap_t straps
);
  always_ff @(posedge clk_ref or negedge pwr_good) begin
    if (!pwr_good)   straps <= '0;
    else if (cap_ev) straps <= '{fs: pad_fs_in, ss: pad_ss_in};
  end
endmodule

// File: rtl/strap_outmux.sv
module strap_outmux
  import strap_pkg::*;
#(
  parameter int N_OTH = 8
) (
  input  phase_t           phase,
  input  logic             src_ref,
  input  logic             src_usb,
  input  logic [N_OTH-1:0] src_oth,
  output logic             pad_fs_oe,
  output logic             pad_fs_out,
  output logic             pad_ss_oe,
  output logic             pad_ss_out,
  output logic [N_OTH-1:0] oth_oe,
  output logic [N_OTH-1:0] oth_out
);
  logic drive_en;
  logic pass_en;

  assign drive_en   = (phase != PH_INPUT);
  assign pass_en    = (phase == PH_RUN);
  assign pad_fs_oe  = drive_en;
  assign pad_ss_oe  = drive_en;
  assign pad_fs_out = pass_en & src_ref;
  assign pad_ss_out = pass_en & src_usb;

  for (genvar i = 0; i < N_OTH; i++) begin : g_oth
    assign oth_oe[i]  = drive_en;
    assign oth_out[i] = pass_en & src_oth[i];
  end
endmodule

// File: rtl/strap_decode.sv
module strap_decode
  import strap_pkg::*;
(
  input  logic        valid,
  input  strap_t      straps,
  input  logic        sel_hi,
  output logic [1:0]  freq_code,
  output logic [15:0] cpu_x100,
  output logic [15:0] pci_x100,
  output logic [6:0]  spread_bp
);
  logic [1:0] code;

  assign code      = freq_code_f(straps.fs, sel_hi);
  assign freq_code = valid ? code : 2'd0;
  assign cpu_x100  = valid ? cpu_x100_f(code) : 16'd0;
  assign pci_x100  = valid ? pci_x100_f(code) : 16'd0;
  assign spread_bp = valid ? spread_bp_f(straps.ss) : 7'd0;
endmodule

// File: rtl/strap_seq.sv
module strap_seq
  import strap_pkg::*;
#(
  parameter int TIMER_CYC = 42954,
  parameter int N_OTH     = 8
) (
  input  logic             clk_ref,
  input  logic             pwr_good,
  input  logic             sel_hi,
  input  logic             pad_fs_in,
  input  logic             pad_ss_in,
  input  logic             src_ref,
  input  logic             src_usb,
  input  logic [N_OTH-1:0] src_oth,
  output logic             pad_fs_oe,
  output logic             pad_fs_out,
  output logic             pad_ss_oe,
  output logic             pad_ss_out,
  output logic [N_OTH-1:0] oth_oe,
  output logic [N_OTH-1:0] oth_out,
  output logic             strap_fs,
  output logic             strap_ss,
  output logic             seq_done,
  output logic [1:0]       freq_code,
  output logic [15:0]      cpu_x100,
  output logic [15:0]      pci_x100,
  output logic [6:0]       spread_bp
);
  phase_t phase;
  logic   cap_ev;
  logic   in_low;
  logic   run;
  strap_t straps;

  strap_timer #(.TIMER_CYC(TIMER_CYC)) u_timer (
    .clk_ref (clk_ref),
    .pwr_good(pwr_good),
    .phase   (phase),
    .cap_ev  (cap_ev),
    .in_low  (in_low),
    .run     (run)
  );

  strap_capture u_cap (
    .clk_ref  (clk_ref),
    .pwr_good (pwr_good),
    .cap_ev   (cap_ev),
    .pad_fs_in(pad_fs_in),
    .pad_ss_in(pad_ss_in),
    .straps   (straps)
  );

  strap_outmux #(.N_OTH(N_OTH)) u_mux (
    .phase     (phase),
    .src_ref   (src_ref),
    .src_usb   (src_usb),
    .src_oth   (src_oth),
    .pad_fs_oe (pad_fs_oe),
    .pad_fs_out(pad_fs_out),
    .pad_ss_oe (pad_ss_oe),
    .pad_ss_out(pad_ss_out),
    .oth_oe    (oth_oe),
    .oth_out   (oth_out)
  );

  strap_decode u_dec (
    .valid    (run),
    .straps   (straps),
    .sel_hi   (sel_hi),
    .freq_code(freq_code),
    .cpu_x100 (cpu_x100),
    .pci_x100 (pci_x100),
    .spread_bp(spread_bp)
  );

  assign strap_fs = straps.fs;
  assign strap_ss = straps.ss;
  assign seq_done = run;
endmodule

// File: rtl/strap_seq_chk.sv
module strap_seq_chk #(
  parameter int TIMER_CYC = 42954,
  parameter int N_OTH     = 8
) (
  input logic             clk_ref,
  input logic             pwr_good,
  input logic             cap_ev,
  input logic             in_low,
  input logic             strap_fs,
  input logic             strap_ss,
  input logic             pad_fs_oe,
  input logic             pad_fs_out,
  input logic             pad_ss_oe,
  input logic             pad_ss_out,
  input logic [N_OTH-1:0] oth_oe,
  input logic [N_OTH-1:0] oth_out,
  input logic             src_ref,
  input logic             seq_done,
  input logic             sel_hi,
  input logic [15:0]      cpu_x100,
  input logic [6:0]       spread_bp
);
  localparam int LW = $clog2(TIMER_CYC + 2) + 1;
  logic [LW-1:0] lcnt;

  always_ff @(posedge clk_ref or negedge pwr_good) begin
    if (!pwr_good)   lcnt <= '0;
    else if (in_low) lcnt <= lcnt + 1'b1;
  end

  always @(posedge clk_ref) begin
    if (!pwr_good)
      AST_INPUT_QUIET: assert (!pad_fs_oe && !pad_ss_oe && oth_oe == '0 && !seq_done
                               && cpu_x100 == 16'd0 && spread_bp == 7'd0); // R1
  end

  AST_ONE_CAPTURE: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    cap_ev |=> !cap_ev); // R2
  AST_LOW_DRIVE: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    in_low |-> (pad_fs_oe && pad_ss_oe && !pad_fs_out && !pad_ss_out
                && oth_oe == '1 && oth_out == '0)); // R3
  AST_LOW_BOUND: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    in_low |-> (lcnt < LW'(TIMER_CYC))); // R4
  AST_DONE_TIME: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    $rose(seq_done) |-> (lcnt == LW'(TIMER_CYC))); // R4
  AST_RUN_PASS: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    seq_done |-> (pad_fs_out == src_ref)); // R5
  AST_STRAP_HOLD: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    !cap_ev |=> ($stable(strap_fs) && $stable(strap_ss))); // R6
  AST_FREQ_TOP: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    (seq_done && strap_fs && sel_hi) |-> (cpu_x100 == 16'd10000)); // R7
  AST_CODES_GATED: assert property (@(posedge clk_ref) disable iff (!pwr_good)
    !seq_done |-> (cpu_x100 == 16'd0 && spread_bp == 7'd0)); // R9
endmodule

bind strap_seq strap_seq_chk #(.TIMER_CYC(TIMER_CYC), .N_OTH(N_OTH)) u_chk (
  .clk_ref   (clk_ref),
  .pwr_good  (pwr_good),
  .cap_ev    (cap_ev),
  .in_low    (in_low),
  .strap_fs  (strap_fs),
  .strap_ss  (strap_ss),
  .pad_fs_oe (pad_fs_oe),
  .pad_fs_out(pad_fs_out),
  .pad_ss_oe (pad_ss_oe),
  .pad_ss_out(pad_ss_out),
  .oth_oe    (oth_oe),
  .oth_out   (oth_out),
  .src_ref   (src_ref),
  .seq_done  (seq_done),
  .sel_hi    (sel_hi),
  .cpu_x100  (cpu_x100),
  .spread_bp (spread_bp)
);

// File: tb/strap_seq_bench.sv
module strap_seq_bench;
  localparam int T = 20;
  localparam int N = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic pwr_good, sel_hi, pad_fs_in, pad_ss_in, src_ref, src_usb;
  logic [N-1:0] src_oth;
  logic pad_fs_oe, pad_fs_out, pad_ss_oe, pad_ss_out;
  logic [N-1:0] oth_oe, oth_out;
  logic strap_fs, strap_ss, seq_done;
  logic [1:0] freq_code;
  logic [15:0] cpu_x100, pci_x100;
  logic [6:0] spread_bp;

  strap_seq #(.TIMER_CYC(T), .N_OTH(N)) u_strap_seq (
    .clk_ref(clk), .pwr_good(pwr_good), .sel_hi(sel_hi),
    .pad_fs_in(pad_fs_in), .pad_ss_in(pad_ss_in),
    .src_ref(src_ref), .src_usb(src_usb), .src_oth(src_oth),
    .pad_fs_oe(pad_fs_oe), .pad_fs_out(pad_fs_out),
    .pad_ss_oe(pad_ss_oe), .pad_ss_out(pad_ss_out),
    .oth_oe(oth_oe), .oth_out(oth_out),
    .strap_fs(strap_fs), .strap_ss(strap_ss), .seq_done(seq_done),
    .freq_code(freq_code), .cpu_x100(cpu_x100), .pci_x100(pci_x100),
    .spread_bp(spread_bp)
  );

  typedef enum {W_PADOE, W_PADOUT, W_OTHOE, W_OTHOUT, W_STRAPS,
                W_DONE, W_FCODE, W_CPU, W_PCI, W_SPREAD} what_t;
  typedef struct {
    string req;
    what_t what;
    int    exp;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // expected tables indexed by {strap, select}
  int cpu_tab [4] = '{10300, 11200, 6680, 10000};
  int pci_tab [4] = '{3433, 3730, 3340, 3330};
  int code_tab[4] = '{3, 2, 1, 0};

  function automatic int observe(what_t w);
    case (w)
      W_PADOE:  return int'({pad_fs_oe, pad_ss_oe});
      W_PADOUT: return int'({pad_fs_out, pad_ss_out});
      W_OTHOE:  return int'(oth_oe);
      W_OTHOUT: return int'(oth_out);
      W_STRAPS: return int'({strap_fs, strap_ss});
      W_DONE:   return int'(seq_done);
      W_FCODE:  return int'(freq_code);
      W_CPU:    return int'(cpu_x100);
      W_PCI:    return int'(pci_x100);
      default:  return int'(spread_bp);
    endcase
  endfunction

  task automatic expect_v(string r, what_t w, int e);
    item_t it;
    it.req = r; it.what = w; it.exp = e;
    q.push_back(it);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_freq(string r, bit fs, bit sel);
    expect_v(r, W_CPU, cpu_tab[{fs, sel}]);
    expect_v(r, W_PCI, pci_tab[{fs, sel}]);
    expect_v(r, W_FCODE, code_tab[{fs, sel}]);
  endtask

  // monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    item_t it;
    int act;
    while (q.size() > 0) begin
      it = q.pop_front();
      act = observe(it.what);
      n_chk++;
      if (act != it.exp) begin
        n_fail++;
        $display("FAIL %s %s: actual %0d expected %0d", it.req, it.what.name(), act, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    pwr_good = 0; sel_hi = 1; pad_fs_in = 1; pad_ss_in = 0;
    src_ref = 0; src_usb = 0; src_oth = '0;
    repeat (3) tick();
    // R1: quiet input phase
    expect_v("R1", W_PADOE, 0);
    expect_v("R1", W_OTHOE, 0);
    expect_v("R1", W_DONE, 0);
    expect_v("R1", W_CPU, 0);
    expect_v("R1", W_SPREAD, 0);
    tick();
    pwr_good = 1;
    tick(); // capture edge
    src_ref = 1; src_usb = 1; src_oth = 3'b111;
    expect_v("R2", W_STRAPS, 2);
    expect_v("R3", W_PADOE, 3);
    expect_v("R3", W_PADOUT, 0);
    expect_v("R3", W_OTHOE, 7);
    expect_v("R3", W_OTHOUT, 0);
    expect_v("R9", W_CPU, 0);
    expect_v("R9", W_SPREAD, 0);
    pad_fs_in = 0; pad_ss_in = 1; // R6: pads move after capture
    repeat (T - 1) tick();
    expect_v("R4", W_DONE, 0);
    tick();
    expect_v("R4", W_DONE, 1);
    expect_v("R5", W_PADOUT, 3);
    expect_v("R5", W_OTHOUT, 7);
    expect_v("R6", W_STRAPS, 2);
    expect_freq("R7", 1, 1);
    expect_v("R8", W_SPREAD, 75);
    tick();
    src_ref = 0; src_usb = 1; src_oth = 3'b101; sel_hi = 0;
    expect_v("R5", W_PADOUT, 1);
    expect_v("R5", W_OTHOUT, 5);
    expect_freq("R7", 1, 0);
    tick();
    pwr_good = 0;
    #1;
    expect_v("R10", W_PADOE, 0);
    expect_v("R10", W_OTHOE, 0);
    expect_v("R10", W_DONE, 0);
    expect_v("R10", W_CPU, 0);
    tick();
    tick();
    pwr_good = 1;
    tick();
    expect_v("R10", W_STRAPS, 1);
    expect_v("R10", W_PADOE, 3);
    repeat (T) tick();
    sel_hi = 1;
    expect_v("R10", W_DONE, 1);
    expect_freq("R7", 0, 1);
    expect_v("R8", W_SPREAD, 50);
    tick();
    sel_hi = 0;
    expect_freq("R7", 0, 0);
    tick();
    tick();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule